// File: doc/BRIEF.md
# Home-Computer Memory Map Decoder

This block turns the 16-bit address of an 8-bit processor into one-hot chip selects for a small home computer. The selects go to a boot monitor ROM, the main DRAM, a video RAM split into a character-code half and a colour half, a keyboard/timer port window and a floppy controller window. The address space is split into 4 KB pages, and the top page bits choose the target.

Two stored bank bits decide what the low page ($0000–$0FFF) and the three high pages ($D000–$FFFF) reach. With a bit clear, that part of the map goes to the ROM or the devices. With a bit set, it goes to plain RAM, so the same address can select different chips depending on the stored state. A normal reset clears both bits. On the first clock edge after reset is released, the "modifier key held" input is copied into both bits, which gives an all-RAM start-up when the key is held. After that, software moves each bit with its own set and clear strobes. For example, it can swap the monitor ROM out for RAM once the monitor has run.

Top module: `memmap_decoder`

## Requirements
- R1: A valid request is `mreq`=1 together with `rd`=1 or `wr`=1. For a valid request exactly one bit of `cs` is 1. The bit meanings are: bit 0 ROM, bit 1 RAM, bit 2 character video RAM, bit 3 colour video RAM, bit 4 keyboard/timer window, bit 5 floppy window.
- R2: When `mreq`=0, or when `rd` and `wr` are both 0, `cs` is all zeros.
- R3: While `rst_n`=0, both bank bits are clear. On the first rising clock edge with `rst_n`=1, both bank bits take the value of `boot_key`. Until that edge, the map is the cleared map.
- R4: Addresses $0000–$0FFF select ROM (bit 0) when the low bank bit is clear, and RAM (bit 1) when it is set.
- R5: Addresses $1000–$CFFF select RAM (bit 1) in every bank state.
- R6: With the high bank bit clear, $D000–$D7FF selects character video RAM (bit 2) and $D800–$DFFF selects colour video RAM (bit 3). Address bit 11 picks between the two halves.
- R7: With the high bank bit clear, $E000–$EFFF selects the keyboard/timer window (bit 4) and $F000–$FFFF selects the floppy window (bit 5). A fetch from $F000 therefore reaches the floppy boot code.
- R8: With the high bank bit set, every address in $D000–$FFFF selects RAM (bit 1).
- R9: After the first edge described in R3, a set strobe makes its bank bit 1 at the next edge, and a clear strobe makes it 0. If both strobes arrive in the same cycle, set wins. With neither strobe, the bit holds its value. On the first edge after reset, all strobes are ignored.
- R10: The low bank bit changes only through `low_set`/`low_clr`, and the high bank bit only through `high_set`/`high_clr`, apart from the load described in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with `clk` |
| boot_key | input | 1 | Modifier key held; copied into both bank bits on the first edge after reset |
| addr | input | 16 | Processor address |
| mreq | input | 1 | Memory request |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| low_set | input | 1 | Map the low page to RAM |
| low_clr | input | 1 | Map the low page to ROM |
| high_set | input | 1 | Map $D000–$FFFF to RAM |
| high_clr | input | 1 | Map $D000–$FFFF to the video RAM and devices |
| cs | output | 6 | One-hot chip selects (bit meanings in R1) |

## Verification
The bench sweeps all sixteen 4 KB pages, with address bit 11 both low and high, in each of the four bank states. Comparing those four sweeps separates a fault in the page decode from a fault in the bank gating, and one in the character/colour split from one in the device windows. Requests with `mreq` low and with both strobes low show whether qualification is missing. Set, clear and simultaneous strobes on one bank bit, with the other bit watched, expose crossed or mis-prioritised state. Two reset releases, one with `boot_key` low and one with it high and a clear strobe on the load edge, test the start-up load and its precedence over the strobes.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

  localparam int NSEL = 6;

  localparam int SEL_ROM  = 0;
  localparam int SEL_RAM  = 1;
  localparam int SEL_VCHR = 2;
  localparam int SEL_VCOL = 3;
  localparam int SEL_KEYT = 4;
  localparam int SEL_FDC  = 5;

  typedef enum logic [2:0] {
    RG_LOW = 3'd0,
    RG_MID = 3'd1,
    RG_VID = 3'd2,
    RG_IO  = 3'd3,
    RG_FDC = 3'd4
  } region_e;

endpackage

// File: rtl/memmap_region_decode.sv
module memmap_region_decode
  import memmap_pkg::*;
#(
  parameter int PAGE_W   = 4,
  parameter int LOW_PAGE = 0,
  parameter int VID_PAGE = 13,
  parameter int IO_PAGE  = 14,
  parameter int FDC_PAGE = 15
) (
  input  logic [PAGE_W:0] addr_hi,
  output region_e         region,
  output logic            vid_upper
);

  logic [PAGE_W-1:0] page;

  assign page      = addr_hi[PAGE_W:1];
  assign vid_upper = addr_hi[0];

  always_comb begin
    if (page == PAGE_W'(LOW_PAGE)) begin
      region = RG_LOW;
    end else if (page == PAGE_W'(VID_PAGE)) begin
      region = RG_VID;
    end else if (page == PAGE_W'(IO_PAGE)) begin
      region = RG_IO;
    end else if (page == PAGE_W'(FDC_PAGE)) begin
      region = RG_FDC;
    end else begin
      region = RG_MID;
    end
  end

endmodule

// File: rtl/memmap_bank_state.sv
module memmap_bank_state (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_key,
  input  logic low_set,
  input  logic low_clr,
  input  logic high_set,
  input  logic high_clr,
  output logic low_is_ram,
  output logic high_is_ram,
  output logic boot_done
);

  logic low_d;
  logic high_d;
  logic done_d;
  logic bank_en;

  always_comb begin
    bank_en = !boot_done || low_set || low_clr || high_set || high_clr;
    done_d  = 1'b1;
    if (!boot_done) begin
      low_d  = boot_key;
      high_d = boot_key;
    end else begin
      low_d  = low_set  || (low_is_ram  && !low_clr);
      high_d = high_set || (high_is_ram && !high_clr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_is_ram  <= 1'b0;
      high_is_ram <= 1'b0;
      boot_done   <= 1'b0;
    end else if (bank_en) begin
      low_is_ram  <= low_d;
      high_is_ram <= high_d;
      boot_done   <= done_d;
    end
  end

endmodule

// File: rtl/memmap_select.sv
module memmap_select
  import memmap_pkg::*;
(
  input  region_e          region,
  input  logic             vid_upper,
  input  logic             low_is_ram,
  input  logic             high_is_ram,
  input  logic             req_valid,
  output logic [NSEL-1:0]  cs
);

  int unsigned sel_idx;

  always_comb begin
    unique case (region)
      RG_LOW:  sel_idx = low_is_ram ? SEL_RAM : SEL_ROM;
      RG_MID:  sel_idx = SEL_RAM;
      RG_VID:  sel_idx = high_is_ram ? SEL_RAM : (vid_upper ? SEL_VCOL : SEL_VCHR);
      RG_IO:   sel_idx = high_is_ram ? SEL_RAM : SEL_KEYT;
      RG_FDC:  sel_idx = high_is_ram ? SEL_RAM : SEL_FDC;
      default: sel_idx = SEL_RAM;
    endcase
  end

  for (genvar gi = 0; gi < NSEL; gi++) begin : g_cs
    assign cs[gi] = req_valid && (sel_idx == gi);
  end

endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import memmap_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int PAGE_W   = 4,
  parameter int LOW_PAGE = 0,
  parameter int VID_PAGE = 13,
  parameter int IO_PAGE  = 14,
  parameter int FDC_PAGE = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_key,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mreq,
  input  logic              rd,
  input  logic              wr,
  input  logic              low_set,
  input  logic              low_clr,
  input  logic              high_set,
  input  logic              high_clr,
  output logic [NSEL-1:0]   cs
);

  localparam int HI_W = PAGE_W + 1;

  logic [HI_W-1:0] addr_hi;
  region_e         region;
  logic            vid_upper;
  logic            low_is_ram;
  logic            high_is_ram;
  logic            boot_done;
  logic            req_valid;

  assign addr_hi   = addr[ADDR_W-1 -: HI_W];
  assign req_valid = mreq && (rd || wr);

  memmap_region_decode #(
    .PAGE_W   (PAGE_W),
    .LOW_PAGE (LOW_PAGE),
    .VID_PAGE (VID_PAGE),
    .IO_PAGE  (IO_PAGE),
    .FDC_PAGE (FDC_PAGE)
  ) i_region (
    .addr_hi   (addr_hi),
    .region    (region),
    .vid_upper (vid_upper)
  );

  memmap_bank_state i_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .boot_key    (boot_key),
    .low_set     (low_set),
    .low_clr     (low_clr),
    .high_set    (high_set),
    .high_clr    (high_clr),
    .low_is_ram  (low_is_ram),
    .high_is_ram (high_is_ram),
    .boot_done   (boot_done)
  );

  memmap_select i_select (
    .region      (region),
    .vid_upper   (vid_upper),
    .low_is_ram  (low_is_ram),
    .high_is_ram (high_is_ram),
    .req_valid   (req_valid),
    .cs          (cs)
  );

endmodule

// File: rtl/memmap_checker.sv
module memmap_checker
  import memmap_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int PAGE_W   = 4,
  parameter int LOW_PAGE = 0,
  parameter int VID_PAGE = 13,
  parameter int IO_PAGE  = 14,
  parameter int FDC_PAGE = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              boot_key,
  input logic [ADDR_W-1:0] addr,
  input logic              mreq,
  input logic              rd,
  input logic              wr,
  input logic              low_set,
  input logic              low_clr,
  input logic              high_set,
  input logic              high_clr,
  input logic [NSEL-1:0]   cs,
  input logic              low_is_ram,
  input logic              high_is_ram,
  input logic              boot_done
);

  logic [PAGE_W-1:0] pg;
  logic              req;
  logic              in_high;

  assign pg      = addr[ADDR_W-1 -: PAGE_W];
  assign req     = mreq && (rd || wr);
  assign in_high = (pg == PAGE_W'(VID_PAGE)) || (pg == PAGE_W'(IO_PAGE)) ||
                   (pg == PAGE_W'(FDC_PAGE));

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> $countones(cs) == 1);

  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> cs == '0);

  a_r3_bootload: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_done |=> (low_is_ram == $past(boot_key)) && (high_is_ram == $past(boot_key)));

  a_r4_rom: assert property (@(posedge clk) disable iff (!rst_n)
    (req && pg == PAGE_W'(LOW_PAGE) && !low_is_ram) |-> cs[SEL_ROM]);

  a_r7_floppy: assert property (@(posedge clk) disable iff (!rst_n)
    (req && pg == PAGE_W'(FDC_PAGE) && !high_is_ram) |-> cs[SEL_FDC]);

  a_r8_high_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (req && in_high && high_is_ram) |-> cs[SEL_RAM]);

  a_r9_low_set: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && low_set) |=> low_is_ram);

  a_r9_high_set: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && high_set) |=> high_is_ram);

  a_r9_low_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && low_clr && !low_set) |=> !low_is_ram);

  a_r10_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && !low_set && !low_clr) |=> $stable(low_is_ram));

  a_r10_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && !high_set && !high_clr) |=> $stable(high_is_ram));

endmodule

bind memmap_decoder memmap_checker #(
  .ADDR_W   (ADDR_W),
  .PAGE_W   (PAGE_W),
  .LOW_PAGE (LOW_PAGE),
  .VID_PAGE (VID_PAGE),
  .IO_PAGE  (IO_PAGE),
  .FDC_PAGE (FDC_PAGE)
) i_memmap_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .boot_key    (boot_key),
  .addr        (addr),
  .mreq        (mreq),
  .rd          (rd),
  .wr          (wr),
  .low_set     (low_set),
  .low_clr     (low_clr),
  .high_set    (high_set),
  .high_clr    (high_clr),
  .cs          (cs),
  .low_is_ram  (low_is_ram),
  .high_is_ram (high_is_ram),
  .boot_done   (boot_done)
);

// File: tb/test_memmap_decoder.sv
module test_memmap_decoder;

  logic        clk;
  logic        rst_n;
  logic        boot_key;
  logic [15:0] addr;
  logic        mreq, rd, wr;
  logic        low_set, low_clr, high_set, high_clr;
  logic [5:0]  cs;

  int checks;
  int errors;
  bit done;

  // reference state
  bit m_low, m_high, m_pend;

  memmap_decoder i_memmap_decoder (
    .clk(clk), .rst_n(rst_n), .boot_key(boot_key), .addr(addr),
    .mreq(mreq), .rd(rd), .wr(wr), .low_set(low_set), .low_clr(low_clr),
    .high_set(high_set), .high_clr(high_clr), .cs(cs)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [5:0] expect_cs(logic [15:0] a, logic q, logic r, logic w,
                                           bit lo, bit hi);
    int pgv;
    if (!(q && (r || w))) return 6'b000000;
    pgv = int'(a[15:12]);
    if (pgv == 0) return lo ? 6'b000010 : 6'b000001;
    if (pgv < 13) return 6'b000010;
    if (hi) return 6'b000010;
    if (pgv == 13) return a[11] ? 6'b001000 : 6'b000100;
    if (pgv == 14) return 6'b010000;
    return 6'b100000;
  endfunction

  function automatic string req_tag(logic [15:0] a, logic q, logic r, logic w, bit hi);
    int pgv;
    pgv = int'(a[15:12]);
    if (!(q && (r || w))) return "R2";
    if (pgv == 0) return "R4";
    if (pgv < 13) return "R5";
    if (hi) return "R8";
    if (pgv == 13) return "R6";
    return "R7";
  endfunction

  // one clock: drive at falling edge, compare before rising edge, advance model at rising edge
  task automatic step(input logic rn, input logic [15:0] a, input logic q, input logic r,
                      input logic w, input logic ls, input logic lc, input logic hs,
                      input logic hc, input string why);
    logic [5:0] exp;
    @(negedge clk);
    rst_n = rn; addr = a; mreq = q; rd = r; wr = w;
    low_set = ls; low_clr = lc; high_set = hs; high_clr = hc;
    if (!rn) begin
      m_low = 0; m_high = 0; m_pend = 1;
    end
    #4;
    exp = expect_cs(a, q, r, w, m_low, m_high);
    checks++;
    if (cs !== exp) begin
      errors++;
      $display("FAIL %s %s addr=%h cs actual=%b expected=%b", req_tag(a, q, r, w, m_high),
               why, a, cs, exp);
    end
    @(posedge clk);
    if (rn) begin
      if (m_pend) begin
        m_low = boot_key; m_high = boot_key; m_pend = 0;
      end else begin
        if (ls) m_low = 1; else if (lc) m_low = 0;
        if (hs) m_high = 1; else if (hc) m_high = 0;
      end
    end
  endtask

  task automatic sweep(input string why);
    for (int p = 0; p < 16; p++) begin
      for (int h = 0; h < 2; h++) begin
        step(1, 16'((p << 12) | (h << 11) | 16'h0123), 1, h[0], !h[0], 0, 0, 0, 0, why);
      end
    end
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    m_low = 0; m_high = 0; m_pend = 1;
    rst_n = 0; boot_key = 0; addr = '0; mreq = 0; rd = 0; wr = 0;
    low_set = 0; low_clr = 0; high_set = 0; high_clr = 0;

    // R3: reset state, cleared map
    step(0, 16'h0000, 1, 1, 0, 0, 0, 0, 0, "R3 reset rom");
    step(0, 16'hF000, 1, 1, 0, 1, 0, 1, 0, "R3 reset floppy");
    // release with key low; strobes on load edge ignored (R9)
    step(1, 16'h0000, 1, 1, 0, 1, 0, 1, 0, "R3 load edge");
    step(1, 16'h0000, 1, 1, 0, 0, 0, 0, 0, "R9 strobe ignored on load");
    step(1, 16'hD000, 1, 0, 1, 0, 0, 0, 0, "R9 strobe ignored on load");

    sweep("R1 sweep low=0 high=0");
    // R2: no request
    step(1, 16'h1234, 0, 1, 1, 0, 0, 0, 0, "R2 mreq low");
    step(1, 16'hF000, 1, 0, 0, 0, 0, 0, 0, "R2 no strobe");

    // R9/R10: set low only, high must stay
    step(1, 16'h0000, 1, 1, 0, 1, 0, 0, 0, "R9 low set");
    sweep("R10 sweep low=1 high=0");
    // set high and clear low
    step(1, 16'h0000, 1, 1, 0, 0, 1, 1, 0, "R9 low clr high set");
    sweep("R10 sweep low=0 high=1");
    step(1, 16'h0000, 1, 1, 0, 1, 0, 0, 0, "R9 low set");
    sweep("R8 sweep low=1 high=1");
    // set wins over clear
    step(1, 16'hE000, 1, 1, 0, 1, 1, 1, 1, "R9 set wins");
    step(1, 16'h0000, 1, 1, 0, 0, 0, 0, 0, "R9 set wins low");
    step(1, 16'hE000, 1, 1, 0, 0, 0, 0, 1, "R9 high clr");
    step(1, 16'hE000, 1, 1, 0, 0, 0, 0, 0, "R10 high clr only");
    step(1, 16'h0000, 1, 0, 1, 0, 0, 0, 0, "R10 low kept");
    step(1, 16'h0FFF, 1, 1, 0, 0, 1, 0, 0, "R9 low clr");
    step(1, 16'h0FFF, 1, 1, 0, 0, 0, 0, 0, "R4 rom back");
    step(1, 16'hF000, 1, 1, 0, 0, 0, 0, 0, "R7 boot vector");
    step(1, 16'hD7FF, 1, 1, 0, 0, 0, 0, 0, "R6 char top");
    step(1, 16'hD800, 1, 0, 1, 0, 0, 0, 0, "R6 colour base");
    step(1, 16'hCFFF, 1, 1, 0, 0, 0, 0, 0, "R5 below video");

    // second reset with key held; clear strobes on load edge ignored
    boot_key = 1;
    step(0, 16'h0000, 1, 1, 0, 0, 0, 0, 0, "R3 reset again");
    step(1, 16'h0000, 1, 1, 0, 0, 1, 0, 1, "R3 load edge key");
    step(1, 16'h0000, 1, 1, 0, 0, 0, 0, 0, "R3 key all ram low");
    step(1, 16'hE000, 1, 1, 0, 0, 0, 0, 0, "R3 key all ram high");
    boot_key = 0;
    step(1, 16'hF000, 1, 1, 0, 0, 0, 0, 0, "R3 key ignored after load");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule